// File: doc/BRIEF.md
# Double-Width Unsigned Divider with Divide-Error Detection

This block is the integer divide unit of a processor execute stage. A single request supplies a dividend that is twice the operand width, split into a high half and a low half, together with an operand-width divisor and a two-bit size code that selects 8, 16, 32 or 64-bit operation. The unit then returns the truncated quotient and the remainder. When the operation cannot produce a valid result, it raises a divide-error fault and writes no quotient or remainder. The 64-bit size is legal only while the `mode64` input is high.

The control is a two-state machine. `ST_IDLE` waits for `start`. The transition *accept-fault* (`ST_IDLE`→`ST_IDLE`) is taken when a request faults. In that case `done` and `fault` are raised on the accepting edge, because a faulting request is recognised before any iteration: the high half of the dividend is at least the divisor, or the divisor is zero, or the 64-bit size is requested outside 64-bit mode. The transition *accept-run* (`ST_IDLE`→`ST_RUN`) loads a restoring radix-2 datapath. The machine stays in `ST_RUN` for N single-bit steps (*step*, `ST_RUN`→`ST_RUN`). The last step, *finish* (`ST_RUN`→`ST_IDLE`), commits the results and pulses `done`.

The operation sizes use these codes: 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Input bits above the selected width are ignored.

Top module: `wide_udiv`

## Requirements
- R1: For size codes 1, 2 and 3, the dividend is {dvd_hi[N-1:0], dvd_lo[N-1:0]} and the divisor is divisor[N-1:0]. A non-faulting result gives quotient = floor(dividend/divisor) zero-extended to 64 bits, and remainder = dividend mod divisor, which is strictly below the divisor. Input bits at N and above have no effect.
- R2: For size code 0 (byte), the dividend is dvd_lo[15:0] and the divisor is divisor[7:0]. The quotient output carries the 8-bit quotient in bits [7:0], the 8-bit remainder in bits [15:8] and zeros above. The remainder output carries the 8-bit remainder, zero-extended.
- R3: When the divisor's selected bits are all zero, the request faults: `fault` is high with `done`, and `quotient` and `remainder` keep their previous values.
- R4: When the true quotient exceeds 2^N-1 (equivalently, the dividend's high half is at least the divisor), the request faults and the results keep their previous values.
- R5: Size code 3 with `mode64` low faults. For size codes 0 to 2, `mode64` has no effect.
- R6: Count the rising edge that accepts `start` as edge 1. A faulting request shows `done` after edge 1. A non-faulting request shows `done` after edge N+1, where N is 8, 16, 32 or 64.
- R7: `done` is high for exactly one cycle per accepted request. `quotient` and `remainder` change only in a cycle where `done` is high.
- R8: `start` is ignored while a division is running. Such a request neither changes the running result nor produces an extra `done`.
- R9: A synchronous reset clears `done`, `fault`, `quotient` and `remainder` and returns the machine to `ST_IDLE`.
- R10: `fault` holds until the next accepted request, and it is cleared on the edge that accepts that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| mode64 | input | 1 | Enables size code 3 |
| size | input | 2 | Operation size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| dvd_hi | input | 64 | Dividend high half (low N bits used) |
| dvd_lo | input | 64 | Dividend low half; in byte mode holds the whole 16-bit dividend |
| divisor | input | 64 | Divisor (low N bits used) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide-error indication, valid with done and held |
| quotient | output | 64 | Quotient (byte mode: packed remainder and quotient) |
| remainder | output | 64 | Remainder |

## Verification
The following properties are checked on every cycle:
- the committed remainder stays below the latched divisor;
- a zero divisor, or a 64-bit request outside 64-bit mode, faults on the next edge;
- results stay stable in every cycle without `done`, and also across a fault;
- the latched operands stay fixed while the machine runs;
- reset leaves `done` and `fault` low.

Exact quotient and remainder values, the byte-mode packing, overflow faults at the high-half boundary, exact latencies for every size, and the ignored mid-run request can only be shown by the bench's sweeps against its arithmetic model.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } op_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep
    import wdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]            hi_i,
    input  logic [XLEN-1:0]            lo_i,
    input  logic [XLEN-1:0]            div_i,
    input  op_size_e                   size_i,
    input  logic                       mode64_i,
    output logic [XLEN-1:0]            rem0_o,
    output logic [XLEN-1:0]            quo0_o,
    output logic [XLEN-1:0]            div_o,
    output logic [$clog2(XLEN+1)-1:0]  steps_o,
    output logic                       fault_o
);
    localparam int CW = $clog2(XLEN+1);

    logic [XLEN-1:0] c_hi    [NUM_SIZES];
    logic [XLEN-1:0] c_lo    [NUM_SIZES];
    logic [XLEN-1:0] c_div   [NUM_SIZES];
    logic [CW-1:0]   c_steps [NUM_SIZES];
    logic            c_ovf   [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int W = XLEN >> (NUM_SIZES - 1 - k);
        logic [W-1:0] h;
        logic [W-1:0] l;
        logic [W-1:0] d;
        if (k == 0) begin : g_packed
            // byte mode: whole dividend sits in the low half input
            assign h = lo_i[2*W-1:W];
            assign l = lo_i[W-1:0];
        end else begin : g_split
            assign h = hi_i[W-1:0];
            assign l = lo_i[W-1:0];
        end
        assign d          = div_i[W-1:0];
        assign c_hi[k]    = XLEN'(h);
        // low half left-aligned so its MSB is shifted out first
        assign c_lo[k]    = XLEN'(l) << (XLEN - W);
        assign c_div[k]   = XLEN'(d);
        assign c_steps[k] = CW'(W);
        // quotient fits in W bits only when h < d; covers d == 0
        assign c_ovf[k]   = (h >= d);
    end

    always_comb begin
        rem0_o  = c_hi[size_i];
        quo0_o  = c_lo[size_i];
        div_o   = c_div[size_i];
        steps_o = c_steps[size_i];
        fault_o = c_ovf[size_i] | ((size_i == SZ_DBL) & ~mode64_i);
    end

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [XLEN-1:0] rem0_i,
    input  logic [XLEN-1:0] quo0_i,
    input  logic [XLEN-1:0] div_i,
    output logic [XLEN-1:0] rem_nxt_o,
    output logic [XLEN-1:0] quo_nxt_o
);
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN:0]   trial;
    logic [XLEN+1:0] diff;
    logic            take;

    always_comb begin
        trial     = {rem_q, quo_q[XLEN-1]};
        diff      = {1'b0, trial} - {2'b00, div_i};
        take      = ~diff[XLEN+1];
        rem_nxt_o = take ? diff[XLEN-1:0] : trial[XLEN-1:0];
        quo_nxt_o = {quo_q[XLEN-2:0], take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            rem_q <= rem0_i;
            quo_q <= quo0_i;
        end else if (step_i) begin
            rem_q <= rem_nxt_o;
            quo_q <= quo_nxt_o;
        end
    end

endmodule

// File: rtl/wdiv_pack.sv
module wdiv_pack
    import wdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_size_e        size_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    logic [XLEN-1:0] c_q [NUM_SIZES];
    logic [XLEN-1:0] c_r [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int W = XLEN >> (NUM_SIZES - 1 - k);
        if (k == 0) begin : g_packed
            assign c_q[k] = XLEN'({rem_i[W-1:0], quo_i[W-1:0]});
        end else begin : g_plain
            assign c_q[k] = XLEN'(quo_i[W-1:0]);
        end
        assign c_r[k] = XLEN'(rem_i[W-1:0]);
    end

    always_comb begin
        quo_o = c_q[size_i];
        rem_o = c_r[size_i];
    end

endmodule

// File: rtl/wide_udiv.sv
module wide_udiv
    import wdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            mode64,
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] dvd_hi,
    input  logic [XLEN-1:0] dvd_lo,
    input  logic [XLEN-1:0] divisor,
    output logic            done,
    output logic            fault,
    output logic [XLEN-1:0] quotient,
    output logic [XLEN-1:0] remainder
);
    localparam int CW = $clog2(XLEN+1);

    div_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    op_size_e        size_q;
    logic [XLEN-1:0] div_q;

    logic [XLEN-1:0] pre_rem0, pre_quo0, pre_div;
    logic [CW-1:0]   pre_steps;
    logic            pre_fault;
    logic [XLEN-1:0] nxt_rem, nxt_quo;
    logic [XLEN-1:0] pk_quo, pk_rem;

    logic accept, load_en, step_en, last_step;

    assign accept    = start && (state_q == ST_IDLE);
    assign load_en   = accept && !pre_fault;
    assign step_en   = (state_q == ST_RUN);
    assign last_step = step_en && (cnt_q == CW'(1));

    wdiv_prep #(.XLEN(XLEN)) u_prep (
        .hi_i     (dvd_hi),
        .lo_i     (dvd_lo),
        .div_i    (divisor),
        .size_i   (op_size_e'(size)),
        .mode64_i (mode64),
        .rem0_o   (pre_rem0),
        .quo0_o   (pre_quo0),
        .div_o    (pre_div),
        .steps_o  (pre_steps),
        .fault_o  (pre_fault)
    );

    wdiv_core #(.XLEN(XLEN)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_en),
        .step_i    (step_en),
        .rem0_i    (pre_rem0),
        .quo0_i    (pre_quo0),
        .div_i     (div_q),
        .rem_nxt_o (nxt_rem),
        .quo_nxt_o (nxt_quo)
    );

    wdiv_pack #(.XLEN(XLEN)) u_pack (
        .size_i (size_q),
        .quo_i  (nxt_quo),
        .rem_i  (nxt_rem),
        .quo_o  (pk_quo),
        .rem_o  (pk_rem)
    );

    // next-state and step counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_en) begin
                    state_d = ST_RUN;
                    cnt_d   = pre_steps;
                end
            end
            ST_RUN: begin
                cnt_d = cnt_q - CW'(1);
                if (last_step) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            size_q  <= SZ_BYTE;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load_en) begin
                size_q <= op_size_e'(size);
                div_q  <= pre_div;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            fault     <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= last_step || (accept && pre_fault);
            if (accept) begin
                fault <= pre_fault;
            end
            if (last_step) begin
                quotient  <= pk_quo;
                remainder <= pk_rem;
            end
        end
    end

endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            mode64,
    input logic [1:0]      size,
    input logic [XLEN-1:0] divisor,
    input logic            done,
    input logic            fault,
    input logic [XLEN-1:0] quotient,
    input logic [XLEN-1:0] remainder,
    input logic            running,
    input logic [XLEN-1:0] div_q
);
    logic [XLEN-1:0] sel_mask;
    logic            zero_div;

    always_comb begin
        sel_mask = '1 >> (XLEN - (8 << size));
        zero_div = (divisor & sel_mask) == '0;
    end

    assert_rem_below_div_R1: assert property (@(posedge clk) disable iff (rst)
        done && !fault |-> remainder < div_q);

    assert_zero_div_faults_R3: assert property (@(posedge clk) disable iff (rst)
        start && !running && zero_div |=> done && fault);

    assert_fault_keeps_results_R4: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> $stable(quotient) && $stable(remainder));

    assert_mode64_gate_R5: assert property (@(posedge clk) disable iff (rst)
        start && !running && size == 2'd3 && !mode64 |=> done && fault);

    assert_results_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient) && $stable(remainder));

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(div_q));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done && !fault);

endmodule

bind wide_udiv wdiv_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode64    (mode64),
    .size      (size),
    .divisor   (divisor),
    .done      (done),
    .fault     (fault),
    .quotient  (quotient),
    .remainder (remainder),
    .running   (state_q == wdiv_pkg::ST_RUN),
    .div_q     (div_q)
);

// File: tb/wide_udiv_tb.sv
`timescale 1ns/1ps
module wide_udiv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode64 = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [63:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic        done, fault;
    logic [63:0] quotient, remainder;

    int checks = 0;
    int failures = 0;
    logic [63:0] last_q = '0, last_r = '0;

    always #2 clk = ~clk;

    wide_udiv u_dut (
        .clk(clk), .rst(rst), .start(start), .mode64(mode64), .size(size),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .done(done), .fault(fault), .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic logic [63:0] wmask(input logic [1:0] sz);
        return (sz == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    function automatic void model(input logic [63:0] hi, lo, dv, input logic [1:0] sz,
                                  input logic m64, output logic f,
                                  output logic [63:0] q, output logic [63:0] r);
        logic [63:0]  m;
        logic [127:0] dvd, qt, rt, d;
        m = wmask(sz);
        if (sz == 2'd0) dvd = 128'(lo[15:0]);
        else            dvd = (128'(hi & m) << (8 << sz)) | 128'(lo & m);
        d = 128'(dv & m);
        f = (d == 0) || (sz == 2'd3 && !m64);
        qt = '0; rt = '0;
        if (!f) begin
            qt = dvd / d;
            rt = dvd % d;
            if (qt > 128'(m)) f = 1'b1;
        end
        if (sz == 2'd0) q = {48'd0, rt[7:0], qt[7:0]};
        else            q = qt[63:0];
        r = rt[63:0];
    endfunction

    task automatic run_op(input logic [63:0] hi, lo, dv, input logic [1:0] sz, input logic m64);
        logic        ef;
        logic [63:0] eq, er;
        int          lat;
        int          n;
        string       tag;
        model(hi, lo, dv, sz, m64, ef, eq, er);
        n = 8 << sz;
        if (ef) begin
            if (sz == 2'd3 && !m64)             tag = "R5";
            else if ((dv & wmask(sz)) == 64'd0) tag = "R3";
            else                                tag = "R4";
        end else begin
            tag = (sz == 2'd0) ? "R2" : "R1";
        end
        @(negedge clk);
        start = 1'b1; dvd_hi = hi; dvd_lo = lo; divisor = dv; size = sz; mode64 = m64;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (!ef) check(fault == 1'b0, "R10", "fault cleared on accept", 64'(fault), 64'd0);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (ef ? 1 : n + 1), "R6", "latency", 64'(lat), 64'(ef ? 1 : n + 1));
        check(fault == ef, tag, "fault flag", 64'(fault), 64'(ef));
        if (ef) begin
            check(quotient == last_q && remainder == last_r, tag, "results held",
                  quotient, last_q);
        end else begin
            check(quotient == eq, tag, "quotient", quotient, eq);
            check(remainder == er, tag, "remainder", remainder, er);
            last_q = eq; last_r = er;
        end
        @(negedge clk);
        check(done == 1'b0, "R7", "done pulse width", 64'(done), 64'd0);
        check(quotient == last_q, "R7", "quotient holds", quotient, last_q);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(4 * 190000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R9", "done after reset", 64'(done), 64'd0);
        check(fault == 1'b0, "R9", "fault after reset", 64'(fault), 64'd0);
        check(quotient == 64'd0, "R9", "quotient after reset", quotient, 64'd0);

        // byte mode sweep over every divisor, corner high bytes (R2, R3, R4)
        for (int d = 0; d < 256; d++) begin
            for (int j = 0; j < 12; j++) begin
                logic [7:0] hb;
                logic [63:0] lo;
                unique case (j % 4)
                    0: hb = 8'(d - 1);
                    1: hb = 8'(d);
                    2: hb = (d == 0) ? 8'($urandom) : 8'($urandom % d);
                    default: hb = 8'd0;
                endcase
                lo = {rnd64() & 64'hFFFF_FFFF_FFFF_0000} | {48'd0, hb, 8'($urandom)};
                run_op(rnd64(), lo, {56'($urandom), 8'(d)}, 2'd0, 1'($urandom));
            end
        end

        // wider sizes: corners and random (R1, R3, R4, R5)
        for (int s = 1; s < 4; s++) begin
            logic [1:0]  sz = 2'(s);
            logic [63:0] m  = wmask(sz);
            logic [63:0] junk;
            junk = ~m;
            run_op(64'd0, rnd64(), 64'd1 | junk, sz, 1'b1);
            run_op(rnd64() & m, rnd64(), 64'd1, sz, 1'b1);
            run_op(m - 64'd1, rnd64(), m, sz, 1'b1);
            run_op(m, rnd64(), m, sz, 1'b1);
            run_op(rnd64(), rnd64(), junk, sz, 1'b1);
            for (int i = 0; i < 120; i++) begin
                logic [63:0] dv, hi;
                dv = rnd64() & m;
                if (i % 3 == 0) dv = dv >> ($urandom % (8 << s));
                if (dv == 0) dv = 64'd7;
                if (i % 10 == 0)     hi = dv;
                else if (i % 10 == 1) hi = dv - 64'd1;
                else                  hi = rnd64() % dv;
                run_op(hi | (rnd64() & ~m), rnd64(), dv | (rnd64() & ~m), sz, 1'b1);
            end
        end
        run_op(64'd1, 64'd5, 64'd9, 2'd3, 1'b0);
        run_op(64'd0, 64'd5, 64'd3, 2'd3, 1'b0);

        // R8: request arriving mid-run must be ignored
        begin
            logic ef;
            logic [63:0] eq, er;
            int lat;
            model(64'h123, 64'hDEAD_BEEF_0BAD_F00D, 64'h8000_0000_0000_0001, 2'd3, 1'b1, ef, eq, er);
            @(negedge clk);
            start = 1'b1; dvd_hi = 64'h123; dvd_lo = 64'hDEAD_BEEF_0BAD_F00D;
            divisor = 64'h8000_0000_0000_0001; size = 2'd3; mode64 = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 1;
            repeat (5) begin @(negedge clk); lat++; end
            start = 1'b1; divisor = 64'd0; size = 2'd0; dvd_lo = 64'h55;
            @(negedge clk);
            start = 1'b0; lat++;
            check(done == 1'b0, "R8", "no done from ignored start", 64'(done), 64'd0);
            while (!done && lat < 100) begin @(negedge clk); lat++; end
            check(lat == 65, "R8", "latency of running op", 64'(lat), 64'd65);
            check(fault == 1'b0, "R8", "no fault from ignored start", 64'(fault), 64'd0);
            check(quotient == eq, "R8", "quotient of running op", quotient, eq);
            check(remainder == er, "R8", "remainder of running op", remainder, er);
            last_q = eq; last_r = er;
            repeat (3) @(negedge clk);
            check(done == 1'b0, "R8", "no late done", 64'(done), 64'd0);
        end

        // R10: fault flag stays until next accepted request
        run_op(64'd0, 64'd10, 64'd0, 2'd1, 1'b0);
        repeat (4) @(negedge clk);
        check(fault == 1'b1, "R10", "fault held while idle", 64'(fault), 64'd1);
        run_op(64'd0, 64'd10, 64'd3, 2'd1, 1'b0);

        summary();
        $finish;
    end

endmodule